// File: doc/BRIEF.md
# Priority Interrupt Arbitration Controller

This block decides, once per clock, whether the processor of an 18-bit machine should be interrupted and by whom. Two schemes compete. The first is a multi-level automatic priority scheme with four hardware levels (0 to 3) and four software levels (4 to 7) above them in number and below them in priority. The second is a single-level program interrupt that is gated by an interrupt-on flag. The block holds the request, active and enable state of the multi-level scheme. It also holds the interrupt-on flag and a short defer counter. It emits a one-cycle grant carrying the granted level and the vector address to jump through.

The surrounding processor reports each instruction fetch, so that the defer counter can count down. It also forwards decoded control pulses: clear-all, debreak-and-restore, release-highest-active-level, interrupt on/off, and a write of the multi-level enable. Taking a program interrupt turns interrupts off. It also loads the defer counter, so that the first instruction of the service routine always runs before any new grant. When the multi-level option is built in, taking a program interrupt also marks level 3 active, so that the program interrupt is treated as a level-3 service.

Top module: `prio_intr_arb`

## Requirements
- R1: After reset the grant output, the taken-program-interrupt flag, the interrupt-on flag, the restore-pending flag and every active bit are all zero.
- R2: With the multi-level enable set, a latched request is granted with a one-cycle grant whose level is the lowest-numbered requested level. The grant appears on the second rising edge after the request line is high at an edge. Active bit n (bit index equals level number) becomes set.
- R3: A pending request is not granted while some active level has a number less than or equal to it. The request stays latched until it is granted or cleared.
- R4: Hardware level n (0 to 3) vectors to octal 50+n. Software level 4+k vectors to octal 40+k. A program interrupt vectors to address 0 and reports level 3.
- R5: Each grant sets exactly one active bit, and the active set gains at most one bit per cycle.
- R6: A release pulse clears only the lowest-numbered active bit.
- R7: No grant of either kind is made while the defer counter is nonzero.
- R8: A program interrupt is granted when its request is high, interrupts are on and the defer counter is zero. It also requires either that the multi-level enable is clear or that none of levels 0 to 3 is active. A multi-level grant takes precedence in the same cycle.
- R9: Taking a program interrupt turns interrupts off, loads the defer counter with 2 and sets active bit 3. A new grant is therefore possible only after two further fetch pulses.
- R10: A clear-all pulse clears the multi-level enable, every latched request and every active bit, and suppresses any grant on that edge.
- R11: A debreak pulse sets the restore-pending flag on the next edge. The next fetch pulse without a debreak clears it.
- R12: The grant output is never high for two consecutive cycles with the same multi-level level.
- R13: The interrupt-on pulse sets the interrupt-on flag and the interrupt-off pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req_i | input | NUM_HW | Hardware level request lines, bit n = level n |
| sw_req_i | input | NUM_SW | Software request set pulses, bit k = level NUM_HW+k |
| pi_req_i | input | 1 | Program interrupt request (level) |
| ion_set_i | input | 1 | Interrupts-on pulse |
| ion_clr_i | input | 1 | Interrupts-off pulse |
| fetch_i | input | 1 | One instruction fetch this cycle |
| caf_i | input | 1 | Clear-all pulse |
| dbr_i | input | 1 | Debreak-and-restore pulse |
| release_i | input | 1 | Release the highest-priority active level |
| api_en_wr_i | input | 1 | Write strobe for the multi-level enable |
| api_en_val_i | input | 1 | Value written to the multi-level enable |
| grant_o | output | 1 | One-cycle grant strobe |
| grant_lvl_o | output | LVL_W | Granted level |
| vector_o | output | VEC_W | Vector address of the grant |
| pi_taken_o | output | 1 | The grant is a program interrupt |
| intr_on_o | output | 1 | Interrupt-on flag |
| active_o | output | NUM_LVL | Active levels, bit n = level n |
| restore_pend_o | output | 1 | Restore-pending flag |

## Verification
The embedded properties assume that every control input is a single-cycle pulse sampled at a rising edge. They also assume that clear-all is never raised in the same cycle as a release, and that fetch never fires twice within one cycle. The stimulus drives every input just after a falling edge and lowers it one cycle later. It asserts only one control pulse at a time, apart from the deliberate case of two level requests raised together. It only holds the program interrupt request high across windows where the expected grants have already been queued.

// File: rtl/pia_pkg.sv
package pia_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_API  = 2'd1,
      SRC_PI   = 2'd2
   } grant_src_e;

endpackage

// File: rtl/pia_ffo.sv
// Lowest-index-first one finder: level 0 is the highest priority.
module pia_ffo #(
   parameter int W = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/pia_defer.sv
// Interrupt-on flag and the post-interrupt defer counter.
module pia_defer #(
   parameter int DEFER_W    = 2,
   parameter int DEFER_LOAD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ion_set_i,
   input  logic ion_clr_i,
   input  logic fetch_i,
   input  logic pi_take_i,
   output logic ion_o,
   output logic defer_idle_o
);

   logic [DEFER_W-1:0] cnt_q;
   logic               ion_q;

   initial begin
      assert (DEFER_LOAD > 0 && DEFER_LOAD < (1 << DEFER_W))
         else $error("pia_defer: DEFER_LOAD does not fit DEFER_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ion_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (pi_take_i)      ion_q <= 1'b0;
         else if (ion_clr_i) ion_q <= 1'b0;
         else if (ion_set_i) ion_q <= 1'b1;

         if (pi_take_i)                       cnt_q <= DEFER_W'(DEFER_LOAD);
         else if (fetch_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ion_o        = ion_q;
   assign defer_idle_o = (cnt_q == '0);

   AST_PI_LOADS_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      pi_take_i |=> (cnt_q == DEFER_W'(DEFER_LOAD) && !ion_q)); // R9
   AST_ION_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ion_set_i && !ion_clr_i && !pi_take_i) |=> ion_q); // R13

endmodule

// File: rtl/pia_lvl_state.sv
// Multi-level enable, latched requests and active levels.
module pia_lvl_state #(
   parameter int NUM_HW = 4,
   parameter int NUM_SW = 4,
   parameter int PI_LVL = 3,
   localparam int NUM_LVL = NUM_HW + NUM_SW,
   localparam int LVL_W   = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_HW-1:0]  hw_req_i,
   input  logic [NUM_SW-1:0]  sw_set_i,
   input  logic               caf_i,
   input  logic               en_wr_i,
   input  logic               en_val_i,
   input  logic               grant_i,
   input  logic [LVL_W-1:0]   grant_lvl_i,
   input  logic               pi_mark_i,
   input  logic               release_i,
   output logic [NUM_LVL-1:0] req_o,
   output logic [NUM_LVL-1:0] active_o,
   output logic               api_en_o
);

   logic [NUM_LVL-1:0] req_q, active_q, raw_req, set_mask, rel_mask, clr_req;
   logic               api_en_q, rel_found;
   logic [LVL_W-1:0]   rel_idx;

   assign raw_req = {sw_set_i, hw_req_i};

   pia_ffo #(.W(NUM_LVL)) i_rel_ffo (
      .vec_i   (active_q),
      .found_o (rel_found),
      .idx_o   (rel_idx)
   );

   for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
      assign set_mask[i] = (grant_i && grant_lvl_i == LVL_W'(i))
                           || (pi_mark_i && i == PI_LVL);
      assign clr_req[i]  = grant_i && grant_lvl_i == LVL_W'(i);
      assign rel_mask[i] = release_i && rel_found && rel_idx == LVL_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q    <= '0;
         active_q <= '0;
         api_en_q <= 1'b0;
      end else if (caf_i) begin
         req_q    <= '0;
         active_q <= '0;
         api_en_q <= 1'b0;
      end else begin
         req_q    <= (req_q & ~clr_req) | raw_req;
         active_q <= (active_q & ~rel_mask) | set_mask;
         if (en_wr_i) api_en_q <= en_val_i;
      end
   end

   assign req_o    = req_q;
   assign active_o = active_q;
   assign api_en_o = api_en_q;

   AST_CAF_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      caf_i |=> (active_q == '0 && req_q == '0 && !api_en_q)); // R10
   AST_ACTIVE_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(active_q) <= $countones($past(active_q)) + 1)); // R5
   AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && active_q != '0 && !caf_i && !grant_i && !pi_mark_i)
      |=> ($countones(active_q) + 1 == $countones($past(active_q)))); // R6

endmodule

// File: rtl/prio_intr_arb.sv
module prio_intr_arb #(
   parameter int NUM_HW      = 4,
   parameter int NUM_SW      = 4,
   parameter int VEC_W       = 15,
   parameter int HW_VEC_BASE = 'o50,
   parameter int SW_VEC_BASE = 'o40,
   parameter int PI_VEC      = 0,
   parameter int DEFER_W     = 2,
   parameter int DEFER_LOAD  = 2,
   parameter bit API_PRESENT = 1'b1,
   localparam int NUM_LVL = NUM_HW + NUM_SW,
   localparam int LVL_W   = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_HW-1:0]  hw_req_i,
   input  logic [NUM_SW-1:0]  sw_req_i,
   input  logic               pi_req_i,
   input  logic               ion_set_i,
   input  logic               ion_clr_i,
   input  logic               fetch_i,
   input  logic               caf_i,
   input  logic               dbr_i,
   input  logic               release_i,
   input  logic               api_en_wr_i,
   input  logic               api_en_val_i,
   output logic               grant_o,
   output logic [LVL_W-1:0]   grant_lvl_o,
   output logic [VEC_W-1:0]   vector_o,
   output logic               pi_taken_o,
   output logic               intr_on_o,
   output logic [NUM_LVL-1:0] active_o,
   output logic               restore_pend_o
);
   import pia_pkg::*;

   localparam int PI_LVL = NUM_HW - 1;

   initial begin
      assert (NUM_HW >= 1 && NUM_SW >= 1)
         else $error("prio_intr_arb: need at least one level of each kind");
      assert (HW_VEC_BASE + NUM_HW <= (1 << VEC_W) && SW_VEC_BASE + NUM_SW <= (1 << VEC_W))
         else $error("prio_intr_arb: vectors do not fit VEC_W");
   end

   logic [NUM_LVL-1:0] req, active;
   logic               api_en, ion, defer_idle;
   logic               p_found, a_found;
   logic [LVL_W-1:0]   p_idx, a_idx;
   logic               api_ok, pi_ok, pi_block, pi_mark;
   grant_src_e         src;
   logic [VEC_W-1:0]   api_vec;

   logic               grant_q, pi_taken_q, restore_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [VEC_W-1:0]   vec_q;

   pia_lvl_state #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .PI_LVL(PI_LVL)) i_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .hw_req_i    (hw_req_i),
      .sw_set_i    (sw_req_i),
      .caf_i       (caf_i),
      .en_wr_i     (api_en_wr_i),
      .en_val_i    (api_en_val_i),
      .grant_i     (api_ok),
      .grant_lvl_i (p_idx),
      .pi_mark_i   (pi_mark),
      .release_i   (release_i),
      .req_o       (req),
      .active_o    (active),
      .api_en_o    (api_en)
   );

   pia_defer #(.DEFER_W(DEFER_W), .DEFER_LOAD(DEFER_LOAD)) i_defer (
      .clk          (clk),
      .rst_n        (rst_n),
      .ion_set_i    (ion_set_i),
      .ion_clr_i    (ion_clr_i),
      .fetch_i      (fetch_i),
      .pi_take_i    (pi_ok),
      .ion_o        (ion),
      .defer_idle_o (defer_idle)
   );

   pia_ffo #(.W(NUM_LVL)) i_req_ffo (
      .vec_i   (req),
      .found_o (p_found),
      .idx_o   (p_idx)
   );

   pia_ffo #(.W(NUM_LVL)) i_act_ffo (
      .vec_i   (active),
      .found_o (a_found),
      .idx_o   (a_idx)
   );

   if (API_PRESENT) begin : g_api
      assign api_ok   = api_en && p_found && (!a_found || p_idx < a_idx)
                        && defer_idle && !caf_i;
      assign pi_block = api_en && (|active[NUM_HW-1:0]);
      assign pi_mark  = pi_ok;
   end else begin : g_pi_only
      assign api_ok   = 1'b0;
      assign pi_block = 1'b0;
      assign pi_mark  = 1'b0;
   end

   assign pi_ok = pi_req_i && ion && defer_idle && !pi_block && !api_ok && !caf_i;

   always_comb begin
      if (api_ok)     src = SRC_API;
      else if (pi_ok) src = SRC_PI;
      else            src = SRC_NONE;
   end

   always_comb begin
      if (int'(p_idx) < NUM_HW)
         api_vec = VEC_W'(HW_VEC_BASE) + VEC_W'(p_idx);
      else
         api_vec = VEC_W'(SW_VEC_BASE) + VEC_W'(p_idx) - VEC_W'(NUM_HW);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q    <= 1'b0;
         pi_taken_q <= 1'b0;
         lvl_q      <= '0;
         vec_q      <= '0;
         restore_q  <= 1'b0;
      end else begin
         unique case (src)
            SRC_API: begin
               grant_q <= 1'b1; pi_taken_q <= 1'b0; lvl_q <= p_idx; vec_q <= api_vec;
            end
            SRC_PI: begin
               grant_q <= 1'b1; pi_taken_q <= 1'b1;
               lvl_q <= LVL_W'(PI_LVL); vec_q <= VEC_W'(PI_VEC);
            end
            default: begin
               grant_q <= 1'b0; pi_taken_q <= 1'b0; lvl_q <= '0; vec_q <= '0;
            end
         endcase
         if (dbr_i)        restore_q <= 1'b1;
         else if (fetch_i) restore_q <= 1'b0;
      end
   end

   assign grant_o        = grant_q;
   assign grant_lvl_o    = lvl_q;
   assign vector_o       = vec_q;
   assign pi_taken_o     = pi_taken_q;
   assign intr_on_o      = ion;
   assign active_o       = active;
   assign restore_pend_o = restore_q;

   function automatic logic [NUM_LVL-1:0] upto_mask(input logic [LVL_W-1:0] l);
      for (int i = 0; i < NUM_LVL; i++) upto_mask[i] = (i <= int'(l));
   endfunction

   AST_DEFER_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !defer_idle |=> !grant_q); // R7
   AST_GRANT_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q && !pi_taken_q) |-> (($past(active) & upto_mask(lvl_q)) == '0)); // R3
   AST_GRANT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q && !pi_taken_q) |-> active[lvl_q]); // R2
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q && !pi_taken_q) |=> !(grant_q && !pi_taken_q && lvl_q == $past(lvl_q))); // R12
   AST_DBR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dbr_i |=> restore_q); // R11
   AST_CAF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      caf_i |=> !grant_q); // R10

endmodule

// File: tb/test_prio_intr_arb.sv
module test_prio_intr_arb;

   typedef struct {
      int lvl;
      int vec;
      bit pi;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  hw_req_i = '0;
   logic [3:0]  sw_req_i = '0;
   logic        pi_req_i = 1'b0, ion_set_i = 1'b0, ion_clr_i = 1'b0, fetch_i = 1'b0;
   logic        caf_i = 1'b0, dbr_i = 1'b0, release_i = 1'b0;
   logic        api_en_wr_i = 1'b0, api_en_val_i = 1'b0;
   logic        grant_o, pi_taken_o, intr_on_o, restore_pend_o;
   logic [2:0]  grant_lvl_o;
   logic [14:0] vector_o;
   logic [7:0]  active_o;

   int   n_chk = 0, n_fail = 0, grants_seen = 0, run = 0, max_run = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   prio_intr_arb i_prio_intr_arb (
      .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req_i), .sw_req_i(sw_req_i),
      .pi_req_i(pi_req_i), .ion_set_i(ion_set_i), .ion_clr_i(ion_clr_i),
      .fetch_i(fetch_i), .caf_i(caf_i), .dbr_i(dbr_i), .release_i(release_i),
      .api_en_wr_i(api_en_wr_i), .api_en_val_i(api_en_val_i),
      .grant_o(grant_o), .grant_lvl_o(grant_lvl_o), .vector_o(vector_o),
      .pi_taken_o(pi_taken_o), .intr_on_o(intr_on_o), .active_o(active_o),
      .restore_pend_o(restore_pend_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_grant(input int lvl, input int vec, input bit pi);
      exp_t e;
      e.lvl = lvl; e.vec = vec; e.pi = pi;
      exp_q.push_back(e);
   endtask

   task automatic drained(input string req);
      tick(4);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   task automatic hw(input int l);
      hw_req_i[l] = 1'b1; tick(1); hw_req_i = '0;
   endtask
   task automatic sw(input int k);
      sw_req_i[k] = 1'b1; tick(1); sw_req_i = '0;
   endtask
   task automatic rel();
      release_i = 1'b1; tick(1); release_i = 1'b0;
   endtask
   task automatic fetch();
      fetch_i = 1'b1; tick(1); fetch_i = 1'b0;
   endtask
   task automatic ion_on();
      ion_set_i = 1'b1; tick(1); ion_set_i = 1'b0;
   endtask
   task automatic api_en(input bit v);
      api_en_wr_i = 1'b1; api_en_val_i = v; tick(1); api_en_wr_i = 1'b0;
   endtask

   // Monitor: pops one expected item per observed grant.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (grant_o) begin
            run++;
            if (run > max_run) max_run = run;
            grants_seen++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R12 unexpected grant", int'(grant_lvl_o), -1);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(int'(grant_lvl_o) == e.lvl, "R2 grant level", int'(grant_lvl_o), e.lvl);
               chk(int'(vector_o) == e.vec, "R4 vector", int'(vector_o), e.vec);
               chk(pi_taken_o == e.pi, "R8 pi taken flag", int'(pi_taken_o), int'(e.pi));
            end
         end else begin
            run = 0;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int g;
      tick(5);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(grant_o == 1'b0 && pi_taken_o == 1'b0, "R1 grant idle", int'(grant_o), 0);
      chk(intr_on_o == 1'b0, "R1 interrupts off", int'(intr_on_o), 0);
      chk(active_o == 8'h00 && restore_pend_o == 1'b0, "R1 active clear", int'(active_o), 0);

      api_en(1'b1);
      // R2 single hardware request
      expect_grant(2, 'o52, 1'b0);
      hw(2);
      drained("R2 level 2 granted");
      chk(active_o == 8'h04, "R5 active after grant", int'(active_o), 'h04);

      // R3 lower priority waits; R6 release lets it through
      g = grants_seen;
      hw(3);
      tick(4);
      chk(grants_seen == g, "R3 level 3 held off", grants_seen, g);
      expect_grant(3, 'o53, 1'b0);
      rel();
      drained("R6 release then level 3");
      chk(active_o == 8'h08, "R6 only level 2 cleared", int'(active_o), 'h08);

      // software level blocked; nested higher hardware grant
      g = grants_seen;
      sw(1);
      tick(4);
      chk(grants_seen == g, "R3 software level 5 held", grants_seen, g);
      expect_grant(0, 'o50, 1'b0);
      hw(0);
      drained("R2 nested level 0");
      chk(active_o == 8'h09, "R5 two active", int'(active_o), 'h09);
      rel();
      tick(2);
      chk(active_o == 8'h08, "R6 lowest released first", int'(active_o), 'h08);
      expect_grant(5, 'o41, 1'b0);
      rel();
      drained("R4 software level 5 vector");
      chk(active_o == 8'h20, "R5 level 5 active", int'(active_o), 'h20);
      rel();

      // simultaneous requests: lowest number wins
      expect_grant(1, 'o51, 1'b0);
      expect_grant(4, 'o40, 1'b0);
      hw_req_i[1] = 1'b1; sw_req_i[0] = 1'b1; tick(1); hw_req_i = '0; sw_req_i = '0;
      tick(4);
      chk(exp_q.size() == 1 && active_o == 8'h02, "R2 priority among two", int'(active_o), 'h02);
      rel();
      drained("R4 level 4 after release");
      rel();
      expect_grant(7, 'o43, 1'b0);
      sw(3);
      drained("R4 level 7 vector");
      rel();
      tick(2);

      // R9 program interrupt with the multi-level scheme on
      ion_on();
      chk(intr_on_o == 1'b1, "R13 interrupts on", int'(intr_on_o), 1);
      expect_grant(3, 0, 1'b1);
      pi_req_i = 1'b1; tick(3); pi_req_i = 1'b0;
      drained("R8 program interrupt taken");
      chk(intr_on_o == 1'b0, "R9 interrupts turned off", int'(intr_on_o), 0);
      chk(active_o == 8'h08, "R9 level 3 marked", int'(active_o), 'h08);
      g = grants_seen;
      hw(1);
      tick(4);
      chk(grants_seen == g, "R7 defer blocks grant", grants_seen, g);
      fetch();
      tick(4);
      chk(grants_seen == g, "R9 one fetch not enough", grants_seen, g);
      expect_grant(1, 'o51, 1'b0);
      fetch();
      drained("R9 grant after two fetches");

      // R8 program interrupt masked by active levels 1 and 3
      ion_on();
      g = grants_seen;
      pi_req_i = 1'b1;
      tick(4);
      chk(grants_seen == g && intr_on_o == 1'b1, "R8 masked by active", grants_seen, g);
      rel();
      tick(4);
      chk(grants_seen == g, "R8 still masked by level 3", grants_seen, g);
      expect_grant(3, 0, 1'b1);
      rel();
      drained("R8 unmasked program interrupt");
      pi_req_i = 1'b0;
      fetch(); fetch();
      rel();
      tick(2);

      // R8 multi-level scheme off: active levels do not mask
      expect_grant(2, 'o52, 1'b0);
      hw(2);
      drained("R2 level 2 again");
      api_en(1'b0);
      ion_on();
      expect_grant(3, 0, 1'b1);
      pi_req_i = 1'b1; tick(3); pi_req_i = 1'b0;
      drained("R8 program interrupt with scheme off");
      chk(active_o == 8'h0C, "R9 level 3 marked again", int'(active_o), 'h0C);
      fetch(); fetch();

      // R10 clear-all
      sw(2);
      caf_i = 1'b1; tick(1); caf_i = 1'b0;
      tick(1);
      chk(active_o == 8'h00, "R10 active wiped", int'(active_o), 0);
      g = grants_seen;
      api_en(1'b1);
      tick(6);
      chk(grants_seen == g, "R10 requests wiped", grants_seen, g);

      // R11 debreak flag
      chk(restore_pend_o == 1'b0, "R11 flag idle", int'(restore_pend_o), 0);
      dbr_i = 1'b1; tick(1); dbr_i = 1'b0;
      chk(restore_pend_o == 1'b1, "R11 flag set", int'(restore_pend_o), 1);
      fetch();
      chk(restore_pend_o == 1'b0, "R11 flag cleared by fetch", int'(restore_pend_o), 0);

      // R13 interrupts off
      ion_on();
      ion_clr_i = 1'b1; tick(1); ion_clr_i = 1'b0;
      chk(intr_on_o == 1'b0, "R13 interrupts off", int'(intr_on_o), 0);

      tick(4);
      chk(max_run == 1, "R12 grant strobe width", max_run, 1);
      chk(exp_q.size() == 0, "R2 no missing grants", exp_q.size(), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule